// File: doc/BRIEF.md
# Start-up Delay Timer with Selectable Reset Delay

This block keeps the processor core in reset after power-on, after a reset event, or after a wake-up from a deep sleep state, and lets it run only once a programmed number of clock cycles has passed. A 2-bit select code chooses the reset-path delay. The short setting is a fixed cycle count for systems whose supply is already supervised. The two longer settings add a millisecond-scale wait for a supply that ramps quickly or slowly. A wake-up from sleep always takes a short fixed path with no millisecond part.

The millisecond part is counted in clock cycles through the `CYCLES_PER_MS` parameter. The default is deliberately small so the block can be simulated at reduced scale; a real instance sets it to the clock frequency in kHz. When the reserved code is selected, the block raises a configuration error flag and falls back to the longest delay. The select code is captured only at the start edge of a sequence.

Top module: `startup_delay_timer`

## Requirements
- R1: While `powerOnRstN` is low, `coreHold` is 1, `ready` is 0 and `cfgInvalid` is 0, without waiting for a clock edge.
- R2: At every clock edge outside reset, `ready` is the complement of `coreHold`. Both change on the same rising edge, the one on which the delay count completes.
- R3: With select code 2'b00 captured, `coreHold` falls on the 14th rising edge after the start edge.
- R4: With select code 2'b01 captured, `coreHold` falls on rising edge 14 + CYCLES_PER_MS*41/10 after the start edge. At the default CYCLES_PER_MS of 20 this is edge 96.
- R5: With select code 2'b10 captured, `coreHold` falls on rising edge 14 + CYCLES_PER_MS*65 after the start edge. At the default this is edge 1314.
- R6: Select code 2'b11 gives the same delay as 2'b10. On the start edge it sets `cfgInvalid` to 1. Any later reset-path start with a valid code clears `cfgInvalid`, and wake sequences leave it unchanged.
- R7: A `wakeReq` sampled high while the core runs (`coreHold` low) becomes a start edge. `coreHold` rises on that edge and falls 6 edges later, whatever the select code. A `wakeReq` seen while `coreHold` is high has no effect.
- R8: `startSel` is captured only on a start edge. Changing it during a running count does not change the delay.
- R9: `rstEvent` sampled high on any rising edge is a reset-path start edge. It aborts a running reset or wake count and restarts the count from zero with the code captured on that edge.
- R10: After `powerOnRstN` rises, the first rising clock edge is a reset-path start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| powerOnRstN | input | 1 | Asynchronous power-on reset, active low |
| rstEvent | input | 1 | Synchronous reset-source indication; starts the reset-path delay |
| wakeReq | input | 1 | Wake-from-sleep request; starts the short wake delay while running |
| startSel | input | 2 | Start-up delay select code |
| coreHold | output | 1 | Active-high reset hold for the core |
| ready | output | 1 | Core released and running |
| cfgInvalid | output | 1 | Reserved select code was captured on the last reset-path start |

## Verification
A wrong count or wrong captured delay shows at the ports as `coreHold` falling on the wrong edge. The error only becomes visible when the sequence ends, which can be up to 1314 cycles after its start edge at default scale. For that reason every sequence is measured edge by edge from its start edge, and the bound checker keeps its own cycle count from the port activity. A stuck state machine shows as `ready` and `coreHold` disagreeing, or as a request that is ignored or taken at the wrong time. `cfgInvalid` is checked on the edge after each start.

// File: rtl/startup_pkg.sv
package startup_pkg;

  typedef enum logic [1:0] {
    ST_ARM   = 2'd0,
    ST_COUNT = 2'd1,
    ST_RUN   = 2'd2
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadReset;
    logic loadWake;
    logic countEn;
  } seqStrobe_t;

endpackage

// File: rtl/startup_ctrl.sv
module startup_ctrl
  import startup_pkg::*;
(
  input  logic       clk,
  input  logic       powerOnRstN,
  input  logic       rstEvent,
  input  logic       wakeReq,
  input  logic       countDone,
  output seqStrobe_t strobe,
  output logic       coreHold,
  output logic       ready
);

  seqState_t state, stateNext;
  logic      readyQ;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    unique case (state)
      ST_ARM: begin
        strobe.loadReset = 1'b1;
        stateNext        = ST_COUNT;
      end
      ST_COUNT: begin
        if (countDone) stateNext = ST_RUN;
        else           strobe.countEn = 1'b1;
      end
      ST_RUN: begin
        if (wakeReq) begin
          strobe.loadWake = 1'b1;
          stateNext       = ST_COUNT;
        end
      end
      default: stateNext = ST_ARM;
    endcase
    // A reset event overrides everything and restarts the reset path
    if (rstEvent) begin
      strobe           = '0;
      strobe.loadReset = 1'b1;
      stateNext        = ST_COUNT;
    end
  end

  always_ff @(posedge clk or negedge powerOnRstN) begin
    if (!powerOnRstN) begin
      state  <= ST_ARM;
      readyQ <= 1'b0;
    end else begin
      state  <= stateNext;
      readyQ <= (stateNext == ST_RUN);
    end
  end

  assign coreHold = (state != ST_RUN);
  assign ready    = readyQ;

endmodule

// File: rtl/startup_datapath.sv
module startup_datapath
  import startup_pkg::*;
#(
  parameter int CYCLES_PER_MS     = 20,
  parameter int RESET_BASE_CYCLES = 14,
  parameter int WAKE_CYCLES       = 6,
  parameter int SHORT_MS_TENTHS   = 41,
  parameter int LONG_MS           = 65
) (
  input  logic       clk,
  input  logic       powerOnRstN,
  input  seqStrobe_t strobe,
  input  logic [1:0] startSel,
  output logic       countDone,
  output logic       cfgInvalid
);

  localparam int SHORT_DELAY = RESET_BASE_CYCLES + (CYCLES_PER_MS * SHORT_MS_TENTHS) / 10;
  localparam int LONG_DELAY  = RESET_BASE_CYCLES + CYCLES_PER_MS * LONG_MS;
  localparam int CNT_W       = $clog2(LONG_DELAY + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] target;
  logic [CNT_W-1:0] resetTarget;
  logic             invalidQ;

  // Reset-path delay decode; the reserved code falls back to the longest delay
  always_comb begin
    unique case (startSel)
      2'b00:   resetTarget = CNT_W'(RESET_BASE_CYCLES);
      2'b01:   resetTarget = CNT_W'(SHORT_DELAY);
      default: resetTarget = CNT_W'(LONG_DELAY);
    endcase
  end

  always_ff @(posedge clk or negedge powerOnRstN) begin
    if (!powerOnRstN) begin
      cnt      <= '0;
      target   <= '0;
      invalidQ <= 1'b0;
    end else if (strobe.loadReset) begin
      cnt      <= '0;
      target   <= resetTarget;
      invalidQ <= (startSel == 2'b11);
    end else if (strobe.loadWake) begin
      cnt    <= '0;
      target <= CNT_W'(WAKE_CYCLES);
    end else if (strobe.countEn) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  assign countDone  = (cnt == target - CNT_W'(1));
  assign cfgInvalid = invalidQ;

endmodule

// File: rtl/startup_delay_timer.sv
module startup_delay_timer
  import startup_pkg::*;
#(
  parameter int CYCLES_PER_MS     = 20,
  parameter int RESET_BASE_CYCLES = 14,
  parameter int WAKE_CYCLES       = 6,
  parameter int SHORT_MS_TENTHS   = 41,
  parameter int LONG_MS           = 65
) (
  input  logic       clk,
  input  logic       powerOnRstN,
  input  logic       rstEvent,
  input  logic       wakeReq,
  input  logic [1:0] startSel,
  output logic       coreHold,
  output logic       ready,
  output logic       cfgInvalid
);

  seqStrobe_t strobe;
  logic       countDone;

  startup_ctrl u_ctrl (
    .clk        (clk),
    .powerOnRstN(powerOnRstN),
    .rstEvent   (rstEvent),
    .wakeReq    (wakeReq),
    .countDone  (countDone),
    .strobe     (strobe),
    .coreHold   (coreHold),
    .ready      (ready)
  );

  startup_datapath #(
    .CYCLES_PER_MS    (CYCLES_PER_MS),
    .RESET_BASE_CYCLES(RESET_BASE_CYCLES),
    .WAKE_CYCLES      (WAKE_CYCLES),
    .SHORT_MS_TENTHS  (SHORT_MS_TENTHS),
    .LONG_MS          (LONG_MS)
  ) u_dp (
    .clk        (clk),
    .powerOnRstN(powerOnRstN),
    .strobe     (strobe),
    .startSel   (startSel),
    .countDone  (countDone),
    .cfgInvalid (cfgInvalid)
  );

endmodule

// File: rtl/startup_checker.sv
module startup_checker #(
  parameter int CYCLES_PER_MS     = 20,
  parameter int RESET_BASE_CYCLES = 14,
  parameter int WAKE_CYCLES       = 6,
  parameter int SHORT_MS_TENTHS   = 41,
  parameter int LONG_MS           = 65
) (
  input logic       clk,
  input logic       powerOnRstN,
  input logic       rstEvent,
  input logic       wakeReq,
  input logic [1:0] startSel,
  input logic       coreHold,
  input logic       ready,
  input logic       cfgInvalid
);

  localparam int SHORT_DELAY = RESET_BASE_CYCLES + (CYCLES_PER_MS * SHORT_MS_TENTHS) / 10;
  localparam int LONG_DELAY  = RESET_BASE_CYCLES + CYCLES_PER_MS * LONG_MS;

  // Independent model of the sequence, built from port activity only
  logic        firstEdge;
  logic        wakeSeq;
  logic [1:0]  capSel;
  logic [31:0] len;
  logic        rstStart;

  assign rstStart = firstEdge || rstEvent;

  always_ff @(posedge clk or negedge powerOnRstN) begin
    if (!powerOnRstN) begin
      firstEdge <= 1'b1;
      wakeSeq   <= 1'b0;
      capSel    <= 2'b00;
      len       <= '0;
    end else begin
      firstEdge <= 1'b0;
      if (rstStart) begin
        len     <= '0;
        wakeSeq <= 1'b0;
        capSel  <= startSel;
      end else if (wakeReq && !coreHold) begin
        len     <= '0;
        wakeSeq <= 1'b1;
      end else if (coreHold) begin
        len <= len + 32'd1;
      end
    end
  end

  assert_ready_complement_R2: assert property (@(posedge clk) disable iff (!powerOnRstN)
    ready != coreHold);

  assert_code00_delay_R3: assert property (@(posedge clk) disable iff (!powerOnRstN)
    ($fell(coreHold) && !wakeSeq && capSel == 2'b00) |-> len == RESET_BASE_CYCLES);

  assert_code01_delay_R4: assert property (@(posedge clk) disable iff (!powerOnRstN)
    ($fell(coreHold) && !wakeSeq && capSel == 2'b01) |-> len == SHORT_DELAY);

  assert_long_delay_R5: assert property (@(posedge clk) disable iff (!powerOnRstN)
    ($fell(coreHold) && !wakeSeq && capSel[1]) |-> len == LONG_DELAY);

  assert_reserved_flag_R6: assert property (@(posedge clk) disable iff (!powerOnRstN)
    (rstStart && startSel == 2'b11) |=> cfgInvalid);

  assert_valid_clears_flag_R6: assert property (@(posedge clk) disable iff (!powerOnRstN)
    (rstStart && startSel != 2'b11) |=> !cfgInvalid);

  assert_wake_delay_R7: assert property (@(posedge clk) disable iff (!powerOnRstN)
    ($fell(coreHold) && wakeSeq) |-> len == WAKE_CYCLES);

  assert_wake_raises_hold_R7: assert property (@(posedge clk) disable iff (!powerOnRstN)
    (wakeReq && !coreHold) |=> coreHold);

  assert_reset_event_holds_R9: assert property (@(posedge clk) disable iff (!powerOnRstN)
    rstEvent |=> (coreHold && !ready));

endmodule

bind startup_delay_timer startup_checker #(
  .CYCLES_PER_MS    (CYCLES_PER_MS),
  .RESET_BASE_CYCLES(RESET_BASE_CYCLES),
  .WAKE_CYCLES      (WAKE_CYCLES),
  .SHORT_MS_TENTHS  (SHORT_MS_TENTHS),
  .LONG_MS          (LONG_MS)
) u_chk (
  .clk        (clk),
  .powerOnRstN(powerOnRstN),
  .rstEvent   (rstEvent),
  .wakeReq    (wakeReq),
  .startSel   (startSel),
  .coreHold   (coreHold),
  .ready      (ready),
  .cfgInvalid (cfgInvalid)
);

// File: tb/test_startup_delay_timer.sv
module test_startup_delay_timer;

  localparam int CPM   = 20;
  localparam int D00   = 14;
  localparam int D01   = 14 + (CPM * 41) / 10;
  localparam int D10   = 14 + CPM * 65;
  localparam int DWAKE = 6;

  logic       clk = 1'b0;
  logic       powerOnRstN = 1'b0;
  logic       rstEvent = 1'b0;
  logic       wakeReq = 1'b0;
  logic [1:0] startSel = 2'b00;
  logic       coreHold, ready, cfgInvalid;

  int checks = 0;
  int errors = 0;
  int n;

  always #10 clk = ~clk;

  startup_delay_timer #(.CYCLES_PER_MS(CPM)) i_startup_delay_timer (
    .clk(clk), .powerOnRstN(powerOnRstN), .rstEvent(rstEvent), .wakeReq(wakeReq),
    .startSel(startSel), .coreHold(coreHold), .ready(ready), .cfgInvalid(cfgInvalid)
  );

  // Stimulus table: code, wake path, expected edges until release, expected flag
  localparam int VEC_N = 8;
  localparam logic [1:0] V_SEL [VEC_N] = '{2'b00, 2'b01, 2'b01, 2'b10, 2'b11, 2'b10, 2'b00, 2'b11};
  localparam bit         V_WAKE[VEC_N] = '{1'b0,  1'b1,  1'b0,  1'b0,  1'b0,  1'b1,  1'b0,  1'b1};
  localparam int         V_DLY [VEC_N] = '{D00,   DWAKE, D01,   D10,   D10,   DWAKE, D00,   DWAKE};
  localparam bit         V_INV [VEC_N] = '{1'b0,  1'b0,  1'b0,  1'b0,  1'b1,  1'b1,  1'b0,  1'b0};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called at a negedge just after a start stimulus is driven; the next posedge is the start edge.
  // injKind: 0 none, 1 change select, 2 reset event, 3 wake request
  task automatic measure(input int injAt, input int injKind, input logic [1:0] injSel, output int cnt);
    int k = 0;
    bit restart = 1'b0;
    cnt = 0;
    @(posedge clk);
    @(negedge clk);
    rstEvent = 1'b0;
    wakeReq  = 1'b0;
    forever begin
      if (injKind != 0 && k == injAt) begin
        case (injKind)
          1: startSel = injSel;
          2: begin rstEvent = 1'b1; startSel = injSel; restart = 1'b1; end
          default: wakeReq = 1'b1;
        endcase
      end
      @(posedge clk);
      k++;
      if (restart) begin cnt = 0; restart = 1'b0; end
      else cnt++;
      @(negedge clk);
      rstEvent = 1'b0;
      wakeReq  = 1'b0;
      if (!coreHold || k > 5000) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: outputs during power-on reset
    repeat (3) @(negedge clk);
    check(coreHold == 1'b1, "R1 hold in reset", coreHold, 1);
    check(ready == 1'b0, "R1 ready in reset", ready, 0);
    check(cfgInvalid == 1'b0, "R1 flag in reset", cfgInvalid, 0);

    // R10, R4: power-on release with code 01
    startSel    = 2'b01;
    powerOnRstN = 1'b1;
    measure(0, 0, 2'b00, n);
    check(n == D01, "R10 R4 power-on delay", n, D01);
    check(ready == 1'b1, "R2 ready on release", ready, 1);

    // Table walk over reset and wake paths
    for (int i = 0; i < VEC_N; i++) begin
      startSel = V_SEL[i];
      if (V_WAKE[i]) wakeReq = 1'b1;
      else           rstEvent = 1'b1;
      measure(0, 0, 2'b00, n);
      check(n == V_DLY[i], V_WAKE[i] ? "R7 wake delay" :
            (V_SEL[i] == 2'b00 ? "R3 code00 delay" :
             (V_SEL[i] == 2'b01 ? "R4 code01 delay" :
              (V_SEL[i] == 2'b10 ? "R5 code10 delay" : "R6 reserved delay"))), n, V_DLY[i]);
      check(cfgInvalid == V_INV[i], "R6 config flag", cfgInvalid, V_INV[i]);
      check(ready == 1'b1 && coreHold == 1'b0, "R2 released state", ready, 1);
    end

    // R8: select change mid-count has no effect
    startSel = 2'b00;
    rstEvent = 1'b1;
    measure(3, 1, 2'b10, n);
    check(n == D00, "R8 select captured at start", n, D00);

    // R9: reset event during a long count restarts with new code
    startSel = 2'b10;
    rstEvent = 1'b1;
    measure(50, 2, 2'b00, n);
    check(n == D00, "R9 restart during count", n, D00);

    // R7: wake during a reset count is ignored
    startSel = 2'b01;
    rstEvent = 1'b1;
    measure(10, 3, 2'b00, n);
    check(n == D01, "R7 wake ignored while holding", n, D01);

    // R9: reset event during a wake sequence takes the reset path
    startSel = 2'b11;
    wakeReq  = 1'b1;
    measure(2, 2, 2'b00, n);
    check(n == D00, "R9 reset aborts wake", n, D00);
    check(cfgInvalid == 1'b0, "R6 flag after valid restart", cfgInvalid, 0);

    // R1: asynchronous power-on reset mid-count, then flag cleared
    startSel = 2'b11;
    rstEvent = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rstEvent = 1'b0;
    repeat (5) @(negedge clk);
    check(cfgInvalid == 1'b1, "R6 flag set by reserved code", cfgInvalid, 1);
    #3 powerOnRstN = 1'b0;
    #1;
    check(coreHold == 1'b1 && ready == 1'b0, "R1 async hold", coreHold, 1);
    check(cfgInvalid == 1'b0, "R1 async flag clear", cfgInvalid, 0);
    @(negedge clk);
    startSel    = 2'b00;
    powerOnRstN = 1'b1;
    measure(0, 0, 2'b00, n);
    check(n == D00, "R10 second power-on delay", n, D00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule